// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block expands an AES cipher key of 128, 192 or 256 bits into the complete encryption round-key schedule. A caller presents the key and a two-bit length code together with a one-cycle start pulse. The block then streams the round keys out one 128-bit beat at a time, each tagged with its round index. It also reports the number of cipher rounds for the chosen length. A done pulse marks the end of the stream.

Internally the engine works on 32-bit schedule words. It produces four of them per cycle from a sliding window of the last eight words. One SubWord unit of four byte substitutions serves all three key lengths. At most one word of any 4-word group ever needs substitution:
- 128-bit keys need one substitution per round key.
- 256-bit keys alternate between a rotated substitution step with a round constant and a plain substitution step.
- 192-bit keys have 6-word steps that straddle the 4-word round keys, so some groups need no substitution at all.

Top module: `aes_key_expander`

## Requirements
- R1: The `key_len` code selects the key size: 2'b00 gives 128 bits and 10 rounds, 2'b01 gives 192 bits and 12 rounds, and 2'b10 gives 256 bits and 14 rounds. `num_rounds` shows the round count of the run in progress.
- R2: Key byte 0 is `key[255:248]`, and it is the most significant byte of word 0. Shorter keys occupy the upper bits of `key`. Round key 0 is `key[255:128]`, with word 0 in `rk_data[127:96]`.
- R3: For a 128-bit key, every round key equals the standard AES expansion, e.g. key 2b7e1516 28aed2a6 abf71588 09cf4f3c yields round key 10 d014f9a8 c9ee2589 e13f0cc8 b6630ca6.
- R4: For a 192-bit key, every round key equals the standard AES expansion. The 6-word steps are packed into 128-bit beats.
- R5: For a 256-bit key, every round key equals the standard AES expansion, and round key 1 is `key[127:0]` unchanged.
- R6: The round constants are used in the order 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36, one per rotating step. For the all-zero 128-bit key, round key 1 is four copies of 62636363.
- R7: A run emits exactly `num_rounds`+1 beats, and `rk_index` counts up from 0 to `num_rounds`.
- R8: While `rk_valid` is high and `rk_ready` is low, `rk_valid`, `rk_data` and `rk_index` hold their values.
- R9: With `rk_ready` held high, the beats come out on consecutive cycles.
- R10: A start with `key_len` = 2'b11 sets `err`, starts no run and emits no beat. The next valid start clears `err`.
- R11: `done` is high for exactly the one cycle that follows the clock edge that accepts the final round key.
- R12: A start pulse while `busy` is high is ignored, as is any key or length change made with it.
- R13: After reset, `rk_valid`, `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled while idle |
| key_len | input | 2 | Key length code |
| key | input | 256 | Cipher key, byte 0 in the top bits |
| rk_ready | input | 1 | Consumer accepts the current beat |
| rk_valid | output | 1 | A round key is on `rk_data` |
| rk_data | output | 128 | Round key, word 0 in the top bits |
| rk_index | output | 4 | Round index of the current beat |
| num_rounds | output | 4 | Round count of the current run |
| done | output | 1 | One-cycle pulse after the last beat is accepted |
| err | output | 1 | Last start carried an invalid length code |
| busy | output | 1 | A run is in progress |

## Verification
The bench targets the word-phase bookkeeping of the 192-bit case, where substitution points fall at different offsets inside successive beats. A wrong phase or window offset corrupts round key 1 or later keys, while round key 0 stays correct. The 256-bit case is checked for the alternation between the two substitution kinds and for the pass-through of round key 1; swapping the two kinds or applying a round constant to the plain step would break round key 2 onward. Backpressure on every third cycle exposes a beat that is dropped, repeated or changed while stalled. A start during a run, carrying a different length and key, would restart the schedule or mix two keys if it were not ignored. The constant wrap from 80 to 1B and 36 shows only in the last 128-bit keys, which the published vector's round key 10 pins down.

// File: rtl/aes_key_expander.sv
module aes_key_expander (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   key_len,
  input  logic [255:0] key,
  input  logic         rk_ready,
  output logic         rk_valid,
  output logic [127:0] rk_data,
  output logic [3:0]   rk_index,
  output logic [3:0]   num_rounds,
  output logic         done,
  output logic         err,
  output logic         busy
);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] v);
    logic [7:0] acc, pw, s;
    acc = 8'h01;
    pw  = v;
    for (int k = 1; k < 8; k++) begin
      pw  = gmul(pw, pw);
      acc = gmul(acc, pw);
    end
    s = acc ^ {acc[6:0], acc[7]} ^ {acc[5:0], acc[7:6]} ^
        {acc[4:0], acc[7:5]} ^ {acc[3:0], acc[7:4]} ^ 8'h63;
    return s;
  endfunction

  logic [31:0] win [8];
  logic [5:0]  wi;
  logic [2:0]  ph;
  logic [7:0]  rcon;
  logic [3:0]  gi, nr, nk;

  logic [31:0] raw [4];
  logic [31:0] fin [4];
  logic [31:0] sin, sout;
  logic        use_sub, use_rot;
  logic [1:0]  sel;
  logic [3:0]  ph4;
  logic        gen;

  assign num_rounds = nr;
  assign gen = busy && (gi <= nr) && (!rk_valid || rk_ready);
  assign ph4 = ({1'b0, ph} + 4'd4 >= nk) ? {1'b0, ph} + 4'd4 - nk : {1'b0, ph} + 4'd4;

  always_comb begin
    logic [3:0] pj;
    logic [2:0] oi;
    logic       kw;
    use_sub = 1'b0;
    use_rot = 1'b0;
    sel     = 2'd0;
    for (int j = 0; j < 4; j++) begin
      kw = ({1'b0, wi} + 7'(j)) < {3'b000, nk};
      pj = {1'b0, ph} + 4'(j);
      if (pj >= nk) pj = pj - nk;
      if (!kw && !use_sub && (pj == 4'd0 || (nk == 4'd8 && pj == 4'd4))) begin
        use_sub = 1'b1;
        use_rot = (pj == 4'd0);
        sel     = 2'(j);
      end
    end
    for (int j = 0; j < 4; j++) begin
      kw = ({1'b0, wi} + 7'(j)) < {3'b000, nk};
      oi = 3'(4'd8 - nk + 4'(j));
      if (kw) raw[j] = win[j];
      else    raw[j] = win[oi] ^ ((j == 0) ? win[7] : raw[(j == 0) ? 0 : j - 1]);
    end
    sin = (sel == 2'd0) ? win[7] : raw[sel - 2'd1];
    if (use_rot) sin = {sin[23:0], sin[31:24]};
    sout = {sbox(sin[31:24]), sbox(sin[23:16]), sbox(sin[15:8]), sbox(sin[7:0])};
    if (use_rot) sout = sout ^ {rcon, 24'h000000};
    for (int j = 0; j < 4; j++) begin
      kw = ({1'b0, wi} + 7'(j)) < {3'b000, nk};
      oi = 3'(4'd8 - nk + 4'(j));
      if (kw) fin[j] = win[j];
      else if (use_sub && sel == 2'(j)) fin[j] = win[oi] ^ sout;
      else fin[j] = win[oi] ^ ((j == 0) ? win[7] : fin[(j == 0) ? 0 : j - 1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      done     <= 1'b0;
      rk_valid <= 1'b0;
      rk_data  <= '0;
      rk_index <= '0;
      wi       <= '0;
      ph       <= '0;
      rcon     <= 8'h01;
      gi       <= '0;
      nr       <= '0;
      nk       <= 4'd4;
      for (int k = 0; k < 8; k++) win[k] <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        if (key_len == 2'b11) begin
          err <= 1'b1;
        end else begin
          err  <= 1'b0;
          busy <= 1'b1;
          nk   <= 4'd4 + {1'b0, key_len, 1'b0};
          nr   <= 4'd10 + {1'b0, key_len, 1'b0};
          wi   <= '0;
          ph   <= '0;
          rcon <= 8'h01;
          gi   <= '0;
          for (int k = 0; k < 8; k++) win[k] <= key[255 - 32*k -: 32];
        end
      end else if (busy) begin
        if (rk_valid && rk_ready) begin
          rk_valid <= 1'b0;
          if (rk_index == nr) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        if (gen) begin
          rk_valid <= 1'b1;
          rk_data  <= {fin[0], fin[1], fin[2], fin[3]};
          rk_index <= gi;
          gi       <= gi + 4'd1;
          wi       <= wi + 6'd4;
          ph       <= ph4[2:0];
          if (use_rot) rcon <= {rcon[6:0], 1'b0} ^ (rcon[7] ? 8'h1b : 8'h00);
          for (int k = 0; k < 4; k++) begin
            win[k]     <= win[k + 4];
            win[k + 4] <= fin[k];
          end
        end
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && !rk_ready |=> rk_valid && $stable(rk_data) && $stable(rk_index)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rk_valid && rk_ready && rk_index == num_rounds)); // R11
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> rk_index <= num_rounds); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rk_valid && !busy); // R10
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && $past(rk_valid && rk_ready) |-> rk_index == $past(rk_index) + 4'd1); // R9
  AST_ROUNDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (num_rounds == 4'd10 || num_rounds == 4'd12 || num_rounds == 4'd14)); // R1

endmodule

// File: tb/aes_key_expander_test.sv
module aes_key_expander_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   key_len = 2'b00;
  logic [255:0] key = '0;
  logic         rk_ready = 1'b0;
  logic         rk_valid;
  logic [127:0] rk_data;
  logic [3:0]   rk_index;
  logic [3:0]   num_rounds;
  logic         done, err, busy;

  always #10 clk = ~clk;

  aes_key_expander uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key(key),
    .rk_ready(rk_ready), .rk_valid(rk_valid), .rk_data(rk_data), .rk_index(rk_index),
    .num_rounds(num_rounds), .done(done), .err(err), .busy(busy));

  int total = 0;
  int bad = 0;
  logic [7:0]   sb [256];
  logic [31:0]  rw [60];
  logic [127:0] got [15];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
      sb[p] = x;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic build_ref(input int nk, input logic [255:0] k);
    logic [7:0] rc [10];
    logic [31:0] t;
    rc = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    for (int i = 0; i < 60; i++) begin
      if (i < nk) rw[i] = k[255 - 32*i -: 32];
      else begin
        t = rw[i-1];
        if (i % nk == 0) t = subw({t[23:0], t[31:24]}) ^ {rc[i/nk - 1], 24'h0};
        else if (nk == 8 && i % nk == 4) t = subw(t);
        rw[i] = rw[i-nk] ^ t;
      end
    end
  endtask

  // mode 0: always ready, 1: ready every third cycle, 2: always ready plus a start during the run
  task automatic run_key(input logic [1:0] len, input logic [255:0] k, input int mode, input string rq);
    int nk, nr, beats, first, lastc, cyc;
    bit fin, held, rdy;
    logic [127:0] hd, ex;
    logic [3:0] hi;
    nk = 4 + 2*len;
    nr = nk + 6;
    build_ref(nk, k);
    @(negedge clk);
    key_len = len; key = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    beats = 0; first = -1; lastc = -1; cyc = 0; fin = 0; held = 0;
    while (!fin && cyc < 400) begin
      if (mode == 2 && cyc == 3) begin
        start = 1'b1; key_len = 2'((len + 1) % 3); key = ~k;
      end else start = 1'b0;
      rdy = (mode == 1) ? (cyc % 3 == 2) : 1'b1;
      rk_ready = rdy;
      if (held) begin
        chk(rk_valid && rk_data == hd && rk_index == hi, "R8 stall hold", rk_data, hd);
        held = 0;
      end
      if (rk_valid) begin
        if (rdy) begin
          ex = {rw[4*beats], rw[4*beats+1], rw[4*beats+2], rw[4*beats+3]};
          chk(rk_data == ex, rq, rk_data, ex);
          chk(rk_index == 4'(beats), "R7 index order", 128'(rk_index), 128'(beats));
          if (beats < 15) got[beats] = rk_data;
          if (first < 0) begin
            first = cyc;
            chk(num_rounds == 4'(nr), "R1 round count", 128'(num_rounds), 128'(nr));
            chk(rk_data == k[255:128], "R2 round key 0", rk_data, k[255:128]);
          end
          beats++;
          if (rk_index == 4'(nr)) begin lastc = cyc; fin = 1; end
        end else begin
          held = 1; hd = rk_data; hi = rk_index;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1 && rk_valid == 1'b0, "R11 done after last beat", 128'(done), 128'(1));
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", 128'(done), 128'(0));
    chk(beats == nr + 1, "R7 beat count", 128'(beats), 128'(nr + 1));
    if (mode != 1) chk(lastc - first == nr, "R9 back-to-back beats", 128'(lastc - first), 128'(nr));
    repeat (3) begin
      @(negedge clk);
      chk(rk_valid == 1'b0 && busy == 1'b0, "R12 no extra run", 128'({rk_valid, busy}), 128'(0));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rk_valid, done, err, busy} == 4'b0000, "R13 reset state", 128'({rk_valid, done, err, busy}), 128'(0));
  endtask

  task automatic t_128();
    run_key(2'b00, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 0, "R3 128-bit schedule");
    chk(got[10] == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R3 known round key 10", got[10],
        128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    run_key(2'b00, {128'h0, 128'h0}, 0, "R6 zero-key schedule");
    chk(got[1] == {4{32'h62636363}}, "R6 first constant", got[1], {4{32'h62636363}});
    run_key(2'b00, {128'hffffffffffffffffffffffffffffffff, 128'h5}, 1, "R3 ones-key stalled");
  endtask

  task automatic t_192();
    run_key(2'b01, {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 1, "R4 192-bit schedule");
    run_key(2'b01, {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'hdead}, 0, "R4 192-bit ramp");
  endtask

  task automatic t_256();
    logic [255:0] k;
    k = 256'h603deb1015ca71be2b73aeb0857d77811f352c073b6108d72d9810a30914dff4;
    run_key(2'b10, k, 0, "R5 256-bit schedule");
    chk(got[1] == k[127:0], "R5 round key 1 passthrough", got[1], k[127:0]);
    run_key(2'b10, {8{32'ha5a55a5a}}, 1, "R5 256-bit stalled");
  endtask

  task automatic t_invalid();
    @(negedge clk);
    key_len = 2'b11; key = {8{32'h12345678}}; start = 1'b1; rk_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R10 error flag", 128'({err, busy}), 128'(2));
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (rk_valid || done) chk(1'b0, "R10 no beats", 128'({rk_valid, done}), 128'(0));
    end
    chk(rk_valid == 1'b0, "R10 silent after invalid", 128'(rk_valid), 128'(0));
    run_key(2'b00, {128'h00112233445566778899aabbccddeeff, 128'h0}, 0, "R3 after error");
    chk(err == 1'b0, "R10 error cleared", 128'(err), 128'(0));
  endtask

  task automatic t_busy_start();
    run_key(2'b01, {192'hfedcba9876543210f0e1d2c3b4a5968778695a4b3c2d1e0f, 64'h0}, 2, "R12 192-bit with start while busy");
    run_key(2'b10, {256'h0f1e2d3c4b5a69788796a5b4c3d2e1f00123456789abcdeffedcba9876543210}, 2, "R12 256-bit with start while busy");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    build_sbox();
    t_reset();
    t_128();
    t_192();
    t_256();
    t_invalid();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule